// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the slave side of a small serial EEPROM reached over a three-wire select/clock/data link. All of its logic runs on one system clock. The serial clock is sampled and its rising edges are detected inside the block. While select is high, the block hunts for a start bit, then collects a two-bit opcode and a word address. With these it serves reads from an internal word array, writes a word, erases a word, or sets or clears a programming-enable latch. Reads return a leading zero followed by the addressed word, most significant bit first. The read keeps streaming consecutive words for as long as select stays high.

The array holds 128 bytes. With `WORD16 = 1` (the default) it is organised as 64 words of 16 bits with a 6-bit address. With `WORD16 = 0` it is 128 words of 8 bits with a 7-bit address. The data output has an enable flag in place of a tri-state driver. The array clears to zero at reset and stands in for nonvolatile cells.

The controller has seven states. `S_IDLE` waits for the start bit. `S_OP` takes the two opcode bits and then moves to `S_ADDR`. `S_ADDR` takes the address bits. At the last address bit it goes to `S_DUMMY` for a read, `S_WDATA` for a write, and `S_HOLD` for any other opcode. `S_WDATA` takes the data bits and then goes to `S_HOLD`. `S_DUMMY` moves to `S_RDATA` on the next serial edge. `S_RDATA` keeps serialising words. `S_HOLD` ignores input. Select low sends every state back to `S_IDLE`.

Top module: `mw_eeprom`

## Requirements
- R1: Reset clears the enable latch and the array to zero and drives `sdo` = 0, `sdo_en` = 0. A write issued right after reset leaves the addressed word at 0.
- R2: While `sel` is high, `sdi` is sampled on rising `sclk` edges. Zeros before the first 1 are skipped. That 1 is the start bit, followed by a 2-bit opcode and then the address, both MSB first. The opcodes are 10 = read, 01 = write (followed by one word of data, MSB first), 11 = erase, and 00 = control.
- R3: With the enable latch clear, write and erase leave the array unchanged.
- R4: A control frame whose top two address bits are 11 sets the enable latch. The latch stays set across any number of later frames until a control frame with top address bits 00 arrives, or reset is applied.
- R5: A read returns the stored word whether the enable latch is set or clear.
- R6: At the rising `sclk` edge that carries the last address bit of a read, `sdo_en` goes high and `sdo` drives a 0. Each following rising edge presents the next word bit, MSB first.
- R7: If `sel` stays high after the last bit of a word, the next rising edge presents the MSB of the word at the next address, with no zero bit in between.
- R8: Streaming past the last address continues at address 0.
- R9: `sel` low discards a partly received frame, including a write still missing data bits, and returns the block to idle.
- R10: A permitted erase sets every bit of the addressed word to 1.
- R11: Outside read output (before the last read address bit, and after `sel` falls), `sdo` = 0 and `sdo_en` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled on `clk` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | High while `sdo` carries read data |

## Verification
The hardest case to reach is the boundary between two streamed words at the top of the address space. There, the serializer must reload from the incremented address, wrap it to zero and insert no zero bit, all on a single serial edge. The stimulus writes distinct patterns to the last and first words, issues one read at the last address and holds select high for 32 data edges. A second hard case is a write whose select drops after some data bits have arrived. This is reached by cutting a frame short and then reading the word back.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        OP_CTL   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OP,
        S_ADDR,
        S_WDATA,
        S_DUMMY,
        S_RDATA,
        S_HOLD
    } mw_state_e;

    localparam logic [1:0] CTL_SET = 2'b11;
    localparam logic [1:0] CTL_CLR = 2'b00;

endpackage

// File: rtl/mw_edge.sv
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter bit WORD16 = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);
    import mw_pkg::*;

    localparam int DW   = WORD16 ? 16 : 8;
    localparam int AW   = WORD16 ? 6 : 7;
    localparam int MAXB = (DW > AW) ? DW : AW;
    localparam int CW   = $clog2(MAXB + 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(DW - 1);
    localparam logic [CW-1:0] DATA_END  = CW'(DW);

    mw_state_e     state, nxt;
    logic          sclk_rise;
    logic [1:0]    op_sh;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q;
    logic [DW-2:0] wdat_q;
    logic [DW-1:0] shreg;
    logic          wel_q;
    logic          step;
    logic          addr_done;
    logic [AW-1:0] full_addr;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_word;
    logic          mem_we;
    logic [AW-1:0] mem_wa;
    logic [DW-1:0] mem_wd;
    mw_op_e        op;

    mw_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .rise (sclk_rise)
    );

    assign step      = sel && sclk_rise;
    assign op        = mw_op_e'(op_sh);
    assign full_addr = {addr_q[AW-2:0], sdi};
    assign addr_done = (state == S_ADDR) && (cnt == ADDR_LAST);
    assign rd_addr   = (state == S_ADDR) ? full_addr : addr_q + 1'b1;

    // array write port: erase at last address bit, write at last data bit
    always_comb begin
        mem_we = 1'b0;
        mem_wa = addr_q;
        mem_wd = {wdat_q, sdi};
        if (step && wel_q) begin
            if (addr_done && op == OP_ERASE) begin
                mem_we = 1'b1;
                mem_wa = full_addr;
                mem_wd = '1;
            end else if (state == S_WDATA && cnt == DATA_LAST) begin
                mem_we = 1'b1;
            end
        end
    end

    mw_array #(.DW(DW), .AW(AW)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_wa),
        .wdata(mem_wd),
        .raddr(rd_addr),
        .rdata(rd_word)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (!sel) begin
            nxt = S_IDLE;
        end else if (sclk_rise) begin
            unique case (state)
                S_IDLE:  if (sdi) nxt = S_OP;
                S_OP:    if (cnt == CW'(1)) nxt = S_ADDR;
                S_ADDR:  if (cnt == ADDR_LAST) begin
                             if (op == OP_READ)       nxt = S_DUMMY;
                             else if (op == OP_WRITE) nxt = S_WDATA;
                             else                     nxt = S_HOLD;
                         end
                S_WDATA: if (cnt == DATA_LAST) nxt = S_HOLD;
                S_DUMMY: nxt = S_RDATA;
                S_RDATA: nxt = S_RDATA;
                S_HOLD:  nxt = S_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_sh  <= '0;
            cnt    <= '0;
            addr_q <= '0;
            wdat_q <= '0;
            shreg  <= '0;
            wel_q  <= 1'b0;
            sdo    <= 1'b0;
            sdo_en <= 1'b0;
        end else if (!sel) begin
            cnt    <= '0;
            sdo    <= 1'b0;
            sdo_en <= 1'b0;
        end else if (sclk_rise) begin
            unique case (state)
                S_IDLE: cnt <= '0;
                S_OP: begin
                    op_sh <= {op_sh[0], sdi};
                    cnt   <= (cnt == CW'(1)) ? '0 : cnt + 1'b1;
                end
                S_ADDR: begin
                    addr_q <= full_addr;
                    cnt    <= (cnt == ADDR_LAST) ? '0 : cnt + 1'b1;
                    if (cnt == ADDR_LAST) begin
                        if (op == OP_READ) begin
                            shreg  <= rd_word;
                            sdo    <= 1'b0;
                            sdo_en <= 1'b1;
                        end else if (op == OP_CTL) begin
                            if (full_addr[AW-1 -: 2] == CTL_SET)      wel_q <= 1'b1;
                            else if (full_addr[AW-1 -: 2] == CTL_CLR) wel_q <= 1'b0;
                        end
                    end
                end
                S_WDATA: begin
                    wdat_q <= {wdat_q[DW-3:0], sdi};
                    cnt    <= cnt + 1'b1;
                end
                S_DUMMY: begin
                    sdo   <= shreg[DW-1];
                    shreg <= {shreg[DW-2:0], 1'b0};
                    cnt   <= CW'(1);
                end
                S_RDATA: begin
                    if (cnt == DATA_END) begin
                        addr_q <= rd_addr;
                        sdo    <= rd_word[DW-1];
                        shreg  <= {rd_word[DW-2:0], 1'b0};
                        cnt    <= CW'(1);
                    end else begin
                        sdo   <= shreg[DW-1];
                        shreg <= {shreg[DW-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                    end
                end
                S_HOLD: cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic sdo,
    input logic sdo_en,
    input logic rise,
    input logic wel,
    input logic we
);
    // R1: reset leaves latch clear and output idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!wel && !sdo && !sdo_en));

    // R3: no array write while programming is disabled
    a_r3_write_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> wel);

    // R4: latch moves only on a serial edge with select high
    a_r4_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rise) |=> $stable(wel));

    // R6: output bit moves only on a serial rising edge while selected
    a_r6_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rise) |=> $stable(sdo));

    // R9: select low turns the output off
    a_r9_desel_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !sdo_en);

    // R11: idle output level is zero
    a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> !sdo);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .sdo   (sdo),
    .sdo_en(sdo_en),
    .rise  (sclk_rise),
    .wel   (wel_q),
    .we    (mem_we)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_en;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    mw_eeprom dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk),
        .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        @(negedge clk); sdi = b; sclk = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic sel_on();
        @(negedge clk); sel = 1'b1; sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic sel_off();
        @(negedge clk); sel = 1'b0; sclk = 1'b0; sdi = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] op, input logic [5:0] a);
        sbit(1'b1);
        for (int i = 1; i >= 0; i--) sbit(op[i]);
        for (int i = 5; i >= 0; i--) sbit(a[i]);
    endtask

    task automatic write_w(input logic [5:0] a, input logic [15:0] d);
        sel_on(); frame(2'b01, a);
        for (int i = 15; i >= 0; i--) sbit(d[i]);
        sel_off();
    endtask

    task automatic cmd(input logic [1:0] op, input logic [5:0] a);
        sel_on(); frame(op, a); sel_off();
    endtask

    task automatic get_word(output logic [15:0] w);
        w = '0;
        for (int i = 0; i < 16; i++) begin
            sbit(1'b0);
            w = {w[14:0], sdo};
        end
    endtask

    task automatic read_w(input string req, input logic [5:0] a, input logic [15:0] exp);
        logic [15:0] w;
        sel_on(); frame(2'b10, a);
        check({req, " dummy R6"}, {30'd0, sdo_en, sdo}, 32'h2);
        get_word(w);
        check(req, {16'd0, w}, {16'd0, exp});
        sel_off();
    endtask

    task automatic t_reset();
        check("R1 R11 reset outputs", {30'd0, sdo_en, sdo}, 32'd0);
        write_w(6'd5, 16'hA5A5);
        read_w("R1 R3 locked write", 6'd5, 16'h0000);
    endtask

    task automatic t_enable_write();
        cmd(2'b00, 6'b110000);
        write_w(6'd5, 16'h1234);
        write_w(6'd6, 16'hBEEF);
        read_w("R2 R6 read word", 6'd5, 16'h1234);
    endtask

    task automatic t_sequential();
        logic [15:0] w;
        sel_on(); frame(2'b10, 6'd5);
        get_word(w);
        check("R6 first word", {16'd0, w}, 32'h1234);
        get_word(w);
        check("R7 next word no dummy", {16'd0, w}, 32'hBEEF);
        check("R11 en during stream", {31'd0, sdo_en}, 32'd1);
        sel_off();
        check("R9 R11 off after sel low", {30'd0, sdo_en, sdo}, 32'd0);
    endtask

    task automatic t_wrap();
        logic [15:0] w;
        write_w(6'd63, 16'hC0DE);
        write_w(6'd0, 16'h0F0F);
        sel_on(); frame(2'b10, 6'd63);
        get_word(w);
        check("R8 last word", {16'd0, w}, 32'hC0DE);
        get_word(w);
        check("R8 wrap to 0", {16'd0, w}, 32'h0F0F);
        sel_off();
    endtask

    task automatic t_erase_persist();
        cmd(2'b11, 6'd6);
        read_w("R10 erase ones", 6'd6, 16'hFFFF);
        write_w(6'd7, 16'h7777);
        read_w("R4 latch persists", 6'd7, 16'h7777);
    endtask

    task automatic t_disable();
        cmd(2'b00, 6'b000000);
        write_w(6'd5, 16'h5555);
        cmd(2'b11, 6'd7);
        read_w("R3 R5 write after disable", 6'd5, 16'h1234);
        read_w("R3 erase after disable", 6'd7, 16'h7777);
    endtask

    task automatic t_abort_zeros();
        cmd(2'b00, 6'b110000);
        sel_on(); frame(2'b01, 6'd5);
        for (int i = 0; i < 8; i++) sbit(1'b1);
        sel_off();
        sel_on();
        sbit(1'b0); sbit(1'b0); sbit(1'b0);
        check("R11 quiet before start", {30'd0, sdo_en, sdo}, 32'd0);
        sel_off();
        sel_on(); sbit(1'b0); sbit(1'b0);
        frame(2'b10, 6'd5);
        begin
            logic [15:0] w;
            get_word(w);
            check("R2 R9 zeros skipped, abort kept word", {16'd0, w}, 32'h1234);
        end
        sel_off();
        sel_on(); sbit(1'b1); sbit(1'b0); sbit(1'b1); sel_off();
        read_w("R9 partial frame dropped", 6'd6, 16'hFFFF);
    endtask

    task automatic t_reset_clears();
        cmd(2'b00, 6'b110000);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        write_w(6'd9, 16'h9999);
        read_w("R1 R4 reset clears latch", 6'd9, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_enable_write();
        t_sequential();
        t_wrap();
        t_erase_persist();
        t_disable();
        t_abort_zeros();
        t_reset_clears();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule